// File: doc/BRIEF.md
# DMA Channel Done and Chain-Termination Controller

This block is the per-channel completion logic of a descriptor-chained DMA engine. It owns the channel's active-low done pin. Depending on a two-bit pin mode, the block drives the pin, samples it, or uses it as an open-drain bidirectional line. When the channel signals completion itself, a chain-end select bit picks one of two patterns. With the bit set, done marks only the final transfer of the whole chain. With the bit clear, done marks the final transfer of every descriptor.

When a device outside the block pulls the pin low during one of this channel's acknowledge cycles, the current work ends early. The chain-end select and chain-enable bits then decide the result. The channel either abandons the whole chain or moves on to the next descriptor. The block sets sticky status flags to match and raises a one-cycle stop-new-access request a fixed number of cycles later.

The engine keeps address generation, bus mastering and descriptor fetch. It supplies the acknowledge, last-transfer and last-descriptor indications. It reacts to the continue, terminate and stop requests. A stop request only blocks new accesses: a bus operation already under way runs to its end, and in dual-address mode that includes the write that follows a started read.

Top module: `dma_done_ctrl`

## Requirements
- R1: In pin mode 2'b10 (push-pull output) with chain-end select 1, done_oe_o is 1 and done_no is 0 only in a cycle where the channel is active and ack_i, last_xfer_i and last_desc_i are all 1. In every other cycle of this mode, done_no is 1.
- R2: In pin mode 2'b10 with chain-end select 0, done_no is 0 in every cycle where the channel is active and ack_i and last_xfer_i are both 1, whatever last_desc_i is.
- R3: In pin modes 2'b00 and 2'b01, done_oe_o is 0 and done_no is 1. After reset, all status flags, all requests and xfer_active_o are 0.
- R4: In pin mode 2'b11 (open drain), done_oe_o is 1 only in a cycle where the channel asserts done, and done_no is 0 in that cycle. A self-asserted done in this mode sets st_ext_o on the next cycle.
- R5: In modes 2'b01 and 2'b11, done_ni passes through a two-flop synchronizer. The cycle in which the synchronized level first goes asserted is the detection cycle. If ack_i is 1 and the channel is active in the detection cycle, the external done is honoured: st_ext_o is set on the next cycle, for either value of chain-end select.
- R6: An honoured external done with chain-end select 1 sets st_chain_o and st_xfer_o, clears xfer_active_o and pulses terminate_o, all on the next cycle.
- R7: An honoured external done with chain-end select 0 and chain enable 1 sets st_xfer_o only, pulses chain_next_o and keeps xfer_active_o at 1.
- R8: An honoured external done with chain-end select 0 and chain enable 0 sets st_xfer_o and st_chain_o, clears xfer_active_o and pulses terminate_o.
- R9: stop_req_o is a one-cycle pulse exactly three cycles after the detection cycle of an honoured external done. It does not occur for an ignored one.
- R10: An external done detected while ack_i is 0 on an active channel changes no status flag, request or xfer_active_o. It sets the sticky st_perr_o.
- R11: The flags are sticky. clr_i bit 0 clears st_ext_o, bit 1 clears st_xfer_o, bit 2 clears st_chain_o and bit 3 clears st_perr_o. A clear and a set of the same flag in one cycle leave the flag set.
- R12: A normal descriptor end (active channel, ack_i and last_xfer_i both 1) sets st_xfer_o. If last_desc_i is 0 and chain enable is 1, it pulses chain_next_o. Otherwise it sets st_chain_o, pulses terminate_o and clears xfer_active_o.
- R13: In modes 2'b00 and 2'b10, the level on done_ni has no effect on any status flag or request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that makes the channel active |
| ack_i | input | 1 | Per-transfer acknowledge strobe of this channel |
| last_xfer_i | input | 1 | Current transfer is the last of its descriptor |
| last_desc_i | input | 1 | Current descriptor is the last of the chain |
| chain_end_i | input | 1 | Chain-end select: done marks the whole chain (1) or each descriptor (0) |
| chain_en_i | input | 1 | Chain enable |
| pin_mode_i | input | 2 | Done-pin mode: 00 off, 01 input, 10 output, 11 open drain |
| clr_i | input | 4 | Write-one-to-clear pulses for the status flags |
| done_ni | input | 1 | Sampled done pin, active low, asynchronous |
| done_no | output | 1 | Done pin drive value, active low |
| done_oe_o | output | 1 | Done pin output enable |
| stop_req_o | output | 1 | Pulse that stops new accesses |
| chain_next_o | output | 1 | Pulse that requests the next descriptor |
| terminate_o | output | 1 | Pulse that ends the channel's work |
| st_ext_o | output | 1 | Sticky external-done flag |
| st_xfer_o | output | 1 | Sticky transfer-complete flag |
| st_chain_o | output | 1 | Sticky chain-complete flag |
| st_perr_o | output | 1 | Sticky protocol-error flag |
| xfer_active_o | output | 1 | Channel is active |

## Verification
The bench builds the block with its default two-stage synchronizer and the fixed stop latency of three cycles. With these values, an honoured pin fall produces its status update three cycles after the pin changes and its stop pulse five cycles after. The bench checks both points cycle-exactly, plus the cycles on either side of the stop pulse. Because the chain-end select and chain-enable bits can be set independently, all three termination results are reachable. So are the open-drain self-assert path and the set-beats-clear collision.

// File: rtl/dma_done_pkg.sv
package dma_done_pkg;
  typedef enum logic [1:0] {
    PIN_OFF = 2'b00,
    PIN_IN  = 2'b01,
    PIN_OUT = 2'b10,
    PIN_OD  = 2'b11
  } pin_mode_e;

  localparam int STOP_LAT = 3;
  localparam int ST_W     = 4;
  localparam int ST_EXT   = 0;
  localparam int ST_XFER  = 1;
  localparam int ST_CHAIN = 2;
  localparam int ST_PERR  = 3;
endpackage

// File: rtl/dma_done_sync.sv
module dma_done_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/dma_done_pin.sv
module dma_done_pin
  import dma_done_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       assert_i,
  output logic       drv_no,
  output logic       oe_o
);
  always_comb begin
    drv_no = 1'b1;
    oe_o   = 1'b0;
    unique case (pin_mode_e'(mode_i))
      PIN_OUT: begin
        oe_o   = 1'b1;
        drv_no = ~assert_i;
      end
      PIN_OD: begin
        // open drain: enable only while pulling low
        oe_o   = assert_i;
        drv_no = ~assert_i;
      end
      default: begin
        oe_o   = 1'b0;
        drv_no = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/dma_done_seq.sv
module dma_done_seq
  import dma_done_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            ack_i,
  input  logic            last_xfer_i,
  input  logic            last_desc_i,
  input  logic            chain_end_i,
  input  logic            chain_en_i,
  input  logic [1:0]      mode_i,
  input  logic            ext_rise_i,
  input  logic            self_done_i,
  input  logic [ST_W-1:0] clr_i,
  output logic            active_o,
  output logic            hon_o,
  output logic            stop_o,
  output logic            next_o,
  output logic            term_o,
  output logic [ST_W-1:0] status_o
);
  logic                active_q;
  logic [ST_W-1:0]     status_q, set_v;
  logic [STOP_LAT-1:0] stop_pipe_q;
  logic                next_q, term_q;
  logic                sample_en, hon, perr_ev;
  logic                desc_end, chain_last, ext_full, ext_cont;
  logic                term_ev, next_ev;

  always_comb begin
    sample_en  = mode_i[0] & active_q;
    hon        = sample_en & ext_rise_i & ack_i;
    perr_ev    = sample_en & ext_rise_i & ~ack_i;
    // an honoured external done overrides a coincident normal end
    desc_end   = active_q & ack_i & last_xfer_i & ~hon;
    chain_last = desc_end & (last_desc_i | ~chain_en_i);
    ext_full   = hon & (chain_end_i | ~chain_en_i);
    ext_cont   = hon & ~chain_end_i & chain_en_i;
    term_ev    = ext_full | chain_last;
    next_ev    = ext_cont | (desc_end & ~chain_last);

    set_v           = '0;
    set_v[ST_EXT]   = hon | (self_done_i & (pin_mode_e'(mode_i) == PIN_OD));
    set_v[ST_XFER]  = hon | desc_end;
    set_v[ST_CHAIN] = term_ev;
    set_v[ST_PERR]  = perr_ev;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      status_q    <= '0;
      stop_pipe_q <= '0;
      next_q      <= 1'b0;
      term_q      <= 1'b0;
    end else begin
      if (start_i)      active_q <= 1'b1;
      else if (term_ev) active_q <= 1'b0;
      status_q    <= (status_q & ~clr_i) | set_v;
      stop_pipe_q <= {stop_pipe_q[STOP_LAT-2:0], hon};
      next_q      <= next_ev;
      term_q      <= term_ev;
    end
  end

  assign active_o = active_q;
  assign hon_o    = hon;
  assign stop_o   = stop_pipe_q[STOP_LAT-1];
  assign next_o   = next_q;
  assign term_o   = term_q;
  assign status_o = status_q;
endmodule

// File: rtl/dma_done_ctrl.sv
module dma_done_ctrl
  import dma_done_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        ack_i,
  input  logic        last_xfer_i,
  input  logic        last_desc_i,
  input  logic        chain_end_i,
  input  logic        chain_en_i,
  input  logic [1:0]  pin_mode_i,
  input  logic [3:0]  clr_i,
  input  logic        done_ni,
  output logic        done_no,
  output logic        done_oe_o,
  output logic        stop_req_o,
  output logic        chain_next_o,
  output logic        terminate_o,
  output logic        st_ext_o,
  output logic        st_xfer_o,
  output logic        st_chain_o,
  output logic        st_perr_o,
  output logic        xfer_active_o
);
  logic            ext_s, ext_q, ext_rise;
  logic            active, hon, self_done;
  logic [ST_W-1:0] status;

  dma_done_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (~done_ni),
    .q_o   (ext_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= 1'b0;
    else         ext_q <= ext_s;
  end
  assign ext_rise = ext_s & ~ext_q;

  assign self_done = active & ack_i & last_xfer_i & (last_desc_i | ~chain_end_i);

  dma_done_pin u_pin (
    .mode_i  (pin_mode_i),
    .assert_i(self_done),
    .drv_no  (done_no),
    .oe_o    (done_oe_o)
  );

  dma_done_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .ack_i      (ack_i),
    .last_xfer_i(last_xfer_i),
    .last_desc_i(last_desc_i),
    .chain_end_i(chain_end_i),
    .chain_en_i (chain_en_i),
    .mode_i     (pin_mode_i),
    .ext_rise_i (ext_rise),
    .self_done_i(self_done),
    .clr_i      (clr_i),
    .active_o   (active),
    .hon_o      (hon),
    .stop_o     (stop_req_o),
    .next_o     (chain_next_o),
    .term_o     (terminate_o),
    .status_o   (status)
  );

  assign xfer_active_o = active;
  assign st_ext_o      = status[ST_EXT];
  assign st_xfer_o     = status[ST_XFER];
  assign st_chain_o    = status[ST_CHAIN];
  assign st_perr_o     = status[ST_PERR];
endmodule

// File: rtl/dma_done_chk.sv
module dma_done_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       ack_i,
  input logic       chain_end_i,
  input logic       chain_en_i,
  input logic [1:0] pin_mode_i,
  input logic       ext_rise_i,
  input logic       hon_i,
  input logic       done_no,
  input logic       done_oe_o,
  input logic       stop_req_o,
  input logic       chain_next_o,
  input logic       terminate_o,
  input logic       st_xfer_o,
  input logic       st_chain_o,
  input logic       st_perr_o,
  input logic       xfer_active_o
);
  // R3
  pin_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_mode_i[1] |-> !done_oe_o);

  // R4
  od_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_mode_i == 2'b11 && done_oe_o) |-> !done_no);

  // R6
  ext_term_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hon_i && chain_end_i && !start_i) |=> (!xfer_active_o && st_chain_o && st_xfer_o && terminate_o));

  // R7
  ext_cont_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hon_i && !chain_end_i && chain_en_i) |=> (chain_next_o && xfer_active_o && !terminate_o));

  // R9 (fixed latency of three cycles)
  stop_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hon_i |-> ##3 stop_req_o);

  // R10
  perr_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_rise_i && pin_mode_i[0] && xfer_active_o && !ack_i) |=> st_perr_o);
endmodule

bind dma_done_ctrl dma_done_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .ack_i        (ack_i),
  .chain_end_i  (chain_end_i),
  .chain_en_i   (chain_en_i),
  .pin_mode_i   (pin_mode_i),
  .ext_rise_i   (ext_rise),
  .hon_i        (hon),
  .done_no      (done_no),
  .done_oe_o    (done_oe_o),
  .stop_req_o   (stop_req_o),
  .chain_next_o (chain_next_o),
  .terminate_o  (terminate_o),
  .st_xfer_o    (st_xfer_o),
  .st_chain_o   (st_chain_o),
  .st_perr_o    (st_perr_o),
  .xfer_active_o(xfer_active_o)
);

// File: tb/sim_dma_done_ctrl.sv
`timescale 1ns/1ps
module sim_dma_done_ctrl;
  localparam int B_DRV = 0, B_OE = 1, B_STOP = 2, B_NEXT = 3, B_TERM = 4;
  localparam int B_EXT = 5, B_XFER = 6, B_CHAIN = 7, B_PERR = 8, B_ACT = 9;

  typedef struct {
    int         due;
    logic [9:0] mask;
    logic [9:0] val;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 0, ack = 0, lx = 0, ld = 0, ces = 0, cen = 0;
  logic [1:0] mode = 2'b00;
  logic [3:0] clr = 4'h0;
  logic done_n = 1'b1;
  logic drv, oe, stop, nxt, term, s_ext, s_xfer, s_chain, s_perr, act;
  logic [9:0] obs;

  int   cyc = 0;
  int   n_cmp = 0, n_bad = 0;
  bit   finished = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  dma_done_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .ack_i(ack),
    .last_xfer_i(lx), .last_desc_i(ld), .chain_end_i(ces), .chain_en_i(cen),
    .pin_mode_i(mode), .clr_i(clr), .done_ni(done_n),
    .done_no(drv), .done_oe_o(oe), .stop_req_o(stop), .chain_next_o(nxt),
    .terminate_o(term), .st_ext_o(s_ext), .st_xfer_o(s_xfer),
    .st_chain_o(s_chain), .st_perr_o(s_perr), .xfer_active_o(act)
  );

  assign obs = {act, s_perr, s_chain, s_xfer, s_ext, term, nxt, stop, oe, drv};

  always @(posedge clk) cyc++;

  // monitor: compare due items at the falling edge
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        n_cmp++;
        if ((obs & q[i].mask) !== (q[i].val & q[i].mask)) begin
          n_bad++;
          $display("FAIL %s cyc=%0d actual=%b expected=%b mask=%b",
                   q[i].tag, cyc, obs & q[i].mask, q[i].val & q[i].mask, q[i].mask);
        end
        q.delete(i);
      end
    end
  end

  function automatic logic [9:0] bm(int b);
    return 10'(1) << b;
  endfunction

  task automatic expect_at(int off, logic [9:0] mask, logic [9:0] val, string tag);
    exp_t e;
    e.due = cyc + off; e.mask = mask; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    settle(3);
    rst_ni = 1'b1;
    // reset state: R3
    expect_at(0, 10'h3FF, bm(B_DRV), "R3 reset");

    // R1/R12: push-pull, chain-end select 1
    tick(); mode = 2'b10; ces = 1; cen = 1; start = 1;
    tick(); start = 0; ack = 1; lx = 1; ld = 0;
    expect_at(0, bm(B_DRV) | bm(B_OE), bm(B_DRV) | bm(B_OE), "R1 mid-chain no done");
    expect_at(1, bm(B_NEXT) | bm(B_XFER) | bm(B_ACT), bm(B_NEXT) | bm(B_XFER) | bm(B_ACT), "R12 continue");
    tick(); ld = 1;
    expect_at(0, bm(B_DRV) | bm(B_OE), bm(B_OE), "R1 chain done");
    expect_at(1, bm(B_TERM) | bm(B_CHAIN) | bm(B_ACT), bm(B_TERM) | bm(B_CHAIN), "R12 chain end");
    tick(); ack = 0; lx = 0; ld = 0; clr = 4'hF;
    expect_at(0, bm(B_DRV) | bm(B_OE), bm(B_DRV) | bm(B_OE), "R1 idle high");
    expect_at(1, bm(B_EXT) | bm(B_XFER) | bm(B_CHAIN) | bm(B_PERR), 10'h0, "R11 clear");
    tick(); clr = 4'h0;

    // R2: per-descriptor done
    tick(); ces = 0; start = 1;
    tick(); start = 0; ack = 1; lx = 1;
    expect_at(0, bm(B_DRV), 10'h0, "R2 per-descriptor done");
    tick(); ack = 0; lx = 0;
    expect_at(0, bm(B_DRV), bm(B_DRV), "R2 release");

    // R3: pin off
    tick(); mode = 2'b00; ces = 1; ack = 1; lx = 1; ld = 1;
    expect_at(0, bm(B_DRV) | bm(B_OE), bm(B_DRV), "R3 pin off");
    tick(); ack = 0; lx = 0; ld = 0;

    // R4: open drain
    tick(); mode = 2'b11; clr = 4'hF; start = 1;
    tick(); clr = 4'h0; start = 0; ack = 1;
    expect_at(0, bm(B_DRV) | bm(B_OE), bm(B_DRV), "R4 released");
    tick(); lx = 1; ld = 1;
    expect_at(0, bm(B_DRV) | bm(B_OE), bm(B_OE), "R4 pull low");
    expect_at(1, bm(B_EXT), bm(B_EXT), "R4 self ext flag");
    tick(); ack = 0; lx = 0; ld = 0;
    expect_at(0, bm(B_OE), 10'h0, "R4 released after");

    // R5/R6/R9: input mode, chain-end select 1
    tick(); mode = 2'b01; ces = 1; cen = 1; clr = 4'hF; start = 1;
    tick(); clr = 4'h0; start = 0; ack = 1; done_n = 0;
    expect_at(3, bm(B_EXT) | bm(B_XFER) | bm(B_CHAIN) | bm(B_ACT) | bm(B_TERM),
              bm(B_EXT) | bm(B_XFER) | bm(B_CHAIN) | bm(B_TERM), "R5 R6 ext terminate");
    expect_at(4, bm(B_STOP), 10'h0, "R9 stop early");
    expect_at(5, bm(B_STOP), bm(B_STOP), "R9 stop at latency");
    expect_at(6, bm(B_STOP), 10'h0, "R9 stop pulse");
    settle(4); done_n = 1; ack = 0; settle(4);

    // R7: open drain, continue chain
    tick(); mode = 2'b11; ces = 0; cen = 1; clr = 4'hF; start = 1;
    tick(); clr = 4'h0; start = 0; ack = 1; done_n = 0;
    expect_at(3, bm(B_EXT) | bm(B_XFER) | bm(B_CHAIN) | bm(B_ACT) | bm(B_NEXT) | bm(B_TERM),
              bm(B_EXT) | bm(B_XFER) | bm(B_ACT) | bm(B_NEXT), "R7 ext continue");
    expect_at(5, bm(B_STOP), bm(B_STOP), "R9 stop on continue");
    settle(4); done_n = 1; ack = 0; settle(4);

    // R8: chain disabled
    tick(); mode = 2'b01; cen = 0; clr = 4'hF;
    tick(); clr = 4'h0; ack = 1; done_n = 0;
    expect_at(3, bm(B_EXT) | bm(B_XFER) | bm(B_CHAIN) | bm(B_ACT) | bm(B_TERM),
              bm(B_EXT) | bm(B_XFER) | bm(B_CHAIN) | bm(B_TERM), "R8 ext no chain");
    settle(4); done_n = 1; ack = 0; settle(4);

    // R10: external done without acknowledge
    tick(); cen = 1; clr = 4'hF; start = 1;
    tick(); clr = 4'h0; start = 0; done_n = 0;
    expect_at(3, bm(B_PERR) | bm(B_EXT) | bm(B_XFER) | bm(B_ACT) | bm(B_TERM) | bm(B_NEXT),
              bm(B_PERR) | bm(B_ACT), "R10 ignored no ack");
    expect_at(5, bm(B_STOP), 10'h0, "R10 R9 no stop");
    settle(4); done_n = 1; settle(4);

    // R13: push-pull mode ignores pin
    tick(); mode = 2'b10; clr = 4'hF;
    tick(); clr = 4'h0; ack = 1; done_n = 0;
    expect_at(3, bm(B_PERR) | bm(B_EXT) | bm(B_XFER) | bm(B_ACT),
              bm(B_ACT), "R13 pin ignored");
    expect_at(5, bm(B_STOP), 10'h0, "R13 no stop");
    settle(4); done_n = 1; ack = 0; settle(4);

    // R11: set beats clear
    tick(); ces = 0; cen = 1; ack = 1; lx = 1; clr = 4'b0010;
    expect_at(1, bm(B_XFER), bm(B_XFER), "R11 set wins");
    tick(); ack = 0; lx = 0;
    expect_at(1, bm(B_XFER), 10'h0, "R11 plain clear");
    tick(); clr = 4'h0;

    settle(6);
    if (q.size() != 0) begin
      n_bad += q.size();
      $display("FAIL pending actual=%0d expected=0", q.size());
    end
    finish_run();
  end
endmodule